// File: doc/BRIEF.md
# Receive queue with trigger level and character timeout

This block holds the receive side of a FIFO-mode serial port. Bytes from the receive shifter, and the zero byte that stands for a detected line break, enter a 16-entry byte queue. The host takes the oldest byte with a data-register read strobe and clears sticky error flags with a line-status read strobe. The block reports the fill level and whether the fill has reached the programmed trigger level. It also raises a timeout-pending flag when data has sat unread for four character times. The interrupt priority logic elsewhere uses these outputs.

Writes to the FIFO control register enable or disable queue mode, flush the queues and pick the trigger level. The character time follows from a four-bit line format (word length, stop bits, parity) and counts a bit-tick input. With the queue disabled, the block acts as a single holding register. The timeout is tracked by a three-state machine. TMR_IDLE is taken at reset, while the queue is disabled, when the queue becomes empty and on a receive flush. The machine moves from any state to TMR_RUN, with the counter at zero, on every receive event and on every data read that leaves bytes behind. It moves from TMR_RUN to TMR_FIRED on the bit tick that completes the timeout window. TMR_FIRED holds until a restart or a return to TMR_IDLE. The timeout-pending output is true exactly in TMR_FIRED.

Top module: `uart_rxq`

## Requirements
- R1: The queue holds up to 16 bytes and `fill_o` reports the count. FIFO control bits 7:6 select the trigger level: 00 = 1 byte, 01 = 4, 10 = 8, 11 = 14. With the queue enabled, `at_trig_o` is 1 exactly when the fill is at or above that level.
- R2: A byte that arrives with the enabled queue holding 16 bytes is discarded. The stored bytes and their order are kept, and `overrun_o` is set.
- R3: A data read returns the oldest byte and removes it. A read of an empty queue returns 0x00. A read that leaves the queue empty clears `data_ready_o` and `break_o`.
- R4: A break event enters 0x00 like a received byte, subject to R2, and sets both `break_o` and `data_ready_o`.
- R5: A line-status read clears `break_o` and `overrun_o`. If a new break or overrun occurs in the same cycle, that flag is set instead.
- R6: One character time is 1 start bit plus `line_fmt_i[1:0]`+5 data bits, plus 1 parity bit when `line_fmt_i[3]` is 1, plus 2 stop bits when `line_fmt_i[2]` is 1 (otherwise 1). `timeout_pend_o` rises on the (4 × character bits)-th bit tick after the last restart. Every receive or break event restarts the count, and so does every data read that leaves bytes in the queue.
- R7: `timeout_pend_o` is never 1 while the queue is empty. Any data read clears it, and so does a receive flush. It is only produced in queue mode.
- R8: FIFO control bit 0 enables the queue, bit 1 flushes the receive queue and bit 2 requests a transmit flush (`tx_flush_o`, in the write cycle). Toggling bit 0 forces both flushes. The block keeps bits 7:6, 3 and 0 of each write. A write equal to that stored value has no effect. The trigger level is loaded only by writes with bit 0 set.
- R9: With the queue disabled, the block holds one byte. A new byte replaces an unread one and sets `overrun_o`. `at_trig_o` equals `data_ready_o`, and no timeout is raised.
- R10: After reset the queue is disabled and empty, all flags are 0, and the trigger level is 1 byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| rx_break_i | input | 1 | Break event strobe (wins over rx_valid_i) |
| data_rd_i | input | 1 | Data-register read strobe |
| lsr_rd_i | input | 1 | Line-status read strobe |
| fctl_we_i | input | 1 | FIFO control write strobe |
| fctl_wdata_i | input | 8 | FIFO control write value |
| line_fmt_i | input | 4 | Line format: [1:0] word length − 5, [2] two stop bits, [3] parity on |
| bit_tick_i | input | 1 | One pulse per bit time |
| rd_data_o | output | 8 | Oldest byte (0x00 when empty), valid in the read cycle |
| fifo_en_o | output | 1 | Queue mode enabled |
| fill_o | output | 5 | Number of stored bytes |
| at_trig_o | output | 1 | Fill at or above trigger level |
| data_ready_o | output | 1 | At least one byte stored |
| break_o | output | 1 | Break flag |
| overrun_o | output | 1 | Overrun flag |
| timeout_pend_o | output | 1 | Character timeout pending |
| tx_flush_o | output | 1 | Transmit queue flush request |

## Verification
The assertions check on every cycle that the fill stays within capacity and that a full queue keeps its head and count when a byte arrives. They also check that an empty read returns zero, that a break sets its flags and that a status read clears them. Other cycle-by-cycle checks: the timeout flag never stands over an empty queue, it only rises on a bit tick, and any data read drops it. A repeated control value leaves the mode and the fill untouched. The bench scenarios are needed for the arithmetic. They sweep all sixteen line formats, showing that the flag rises on exactly the computed tick and not one earlier. They also cover restart by reads and by new bytes, byte order across all four trigger levels with fill-by-fill trigger checks, and the single-register behaviour with the queue disabled.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    typedef enum logic [1:0] {
        TMR_IDLE  = 2'd0,
        TMR_RUN   = 2'd1,
        TMR_FIRED = 2'd2
    } tmr_state_e;

    // Bits in one character: start + data + optional parity + stop.
    function automatic logic [3:0] char_bits(input logic [3:0] fmt);
        logic [3:0] n;
        n = 4'd6 + {2'b00, fmt[1:0]} + {3'b000, fmt[3]} + (fmt[2] ? 4'd2 : 4'd1);
        return n;
    endfunction

    // Trigger code to byte count, limited to the queue depth.
    function automatic int unsigned trig_bytes(input logic [1:0] code,
                                               input int unsigned depth);
        int unsigned v;
        unique case (code)
            2'd0:    v = 1;
            2'd1:    v = 4;
            2'd2:    v = 8;
            default: v = 14;
        endcase
        return (v > depth) ? depth : v;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             single_i,
    input  logic             push_i,
    input  logic [DW-1:0]    push_data_i,
    input  logic             pop_i,
    output logic [DW-1:0]    head_o,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] count_nxt_o,
    output logic             drop_o
);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic             full, pop_ok, wr_norm, wr_over;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        full    = single_i ? (count_q != '0) : (count_q == CNT_W'(DEPTH));
        pop_ok  = pop_i && (count_q != '0);
        wr_norm = push_i && (!full || pop_ok);
        wr_over = push_i && full && !pop_ok && single_i;
        drop_o  = push_i && full && !pop_ok && !clear_i;
        if (clear_i) begin
            count_nxt_o = '0;
        end else begin
            count_nxt_o = count_q + CNT_W'(wr_norm) - CNT_W'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            count_q  <= '0;
        end else if (clear_i) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
            if (wr_norm) wr_ptr_q <= ptr_inc(wr_ptr_q);
            count_q <= count_nxt_o;
        end
    end

    always_ff @(posedge clk) begin
        if (!clear_i) begin
            if (wr_norm)      mem[wr_ptr_q] <= push_data_i;
            else if (wr_over) mem[rd_ptr_q] <= push_data_i;
        end
    end

    assign head_o  = (count_q != '0) ? mem[rd_ptr_q] : '0;
    assign count_o = count_q;

    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    p_full_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !single_i && push_i && !pop_i && count_q == CNT_W'(DEPTH))
        |=> (count_q == CNT_W'(DEPTH) && $stable(rd_ptr_q)));

    p_single_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        single_i |-> (count_q <= CNT_W'(1)));

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer
    import uart_rxq_pkg::*;
#(
    parameter int TO_CHARS = 4,
    localparam int TW = $clog2(TO_CHARS * 12 + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable_i,
    input  logic       halt_i,
    input  logic       restart_i,
    input  logic       tick_i,
    input  logic [3:0] fmt_i,
    input  logic       nonempty_i,
    output logic       pend_o
);

    tmr_state_e    st_q, st_d;
    logic [TW-1:0] cnt_q, cnt_d;
    logic [TW-1:0] limit;

    assign limit = TW'(TO_CHARS) * TW'(char_bits(fmt_i));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TMR_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!enable_i || halt_i) begin
            st_d  = TMR_IDLE;
            cnt_d = '0;
        end else if (restart_i) begin
            st_d  = TMR_RUN;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                TMR_IDLE: begin
                    cnt_d = '0;
                end
                TMR_RUN: begin
                    if (tick_i) begin
                        if (cnt_q >= (limit - TW'(1))) begin
                            st_d  = TMR_FIRED;
                            cnt_d = '0;
                        end else begin
                            cnt_d = cnt_q + TW'(1);
                        end
                    end
                end
                TMR_FIRED: begin
                    cnt_d = '0;
                end
                default: begin
                    st_d  = TMR_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        pend_o = (st_q == TMR_FIRED);
    end

    p_pend_needs_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o |-> nonempty_i);

    p_fire_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_o) |-> $past(tick_i));

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int DW       = 8,
    parameter int TO_CHARS = 4,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid_i,
    input  logic [DW-1:0]    rx_byte_i,
    input  logic             rx_break_i,
    input  logic             data_rd_i,
    input  logic             lsr_rd_i,
    input  logic             fctl_we_i,
    input  logic [7:0]       fctl_wdata_i,
    input  logic [3:0]       line_fmt_i,
    input  logic             bit_tick_i,
    output logic [DW-1:0]    rd_data_o,
    output logic             fifo_en_o,
    output logic [CNT_W-1:0] fill_o,
    output logic             at_trig_o,
    output logic             data_ready_o,
    output logic             break_o,
    output logic             overrun_o,
    output logic             timeout_pend_o,
    output logic             tx_flush_o
);

    localparam int          B_EN    = 0;
    localparam int          B_RXCLR = 1;
    localparam int          B_TXCLR = 2;
    localparam logic [7:0]  KEEP    = 8'hC9;

    logic [7:0]       fcr_q;
    logic [1:0]       trig_code_q;
    logic             brk_q, ovr_q;
    logic             fcr_hit, en_flip, rx_clear;
    logic             push;
    logic [DW-1:0]    push_data;
    logic [CNT_W-1:0] count, count_nxt, trig_lvl;
    logic             drop;
    logic             empties;

    // FIFO control decode
    always_comb begin
        fcr_hit    = fctl_we_i && (fctl_wdata_i != fcr_q);
        en_flip    = fcr_hit && (fctl_wdata_i[B_EN] != fcr_q[B_EN]);
        rx_clear   = fcr_hit && (fctl_wdata_i[B_RXCLR] || en_flip);
        tx_flush_o = fcr_hit && (fctl_wdata_i[B_TXCLR] || en_flip);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fcr_q       <= '0;
            trig_code_q <= '0;
        end else if (fcr_hit) begin
            fcr_q <= fctl_wdata_i & KEEP;
            if (fctl_wdata_i[B_EN]) trig_code_q <= fctl_wdata_i[7:6];
        end
    end

    assign push      = rx_valid_i || rx_break_i;
    assign push_data = rx_break_i ? '0 : rx_byte_i;

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (rx_clear),
        .single_i    (!fcr_q[B_EN]),
        .push_i      (push),
        .push_data_i (push_data),
        .pop_i       (data_rd_i),
        .head_o      (rd_data_o),
        .count_o     (count),
        .count_nxt_o (count_nxt),
        .drop_o      (drop)
    );

    rxq_timer #(.TO_CHARS(TO_CHARS)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (fcr_q[B_EN]),
        .halt_i     (rx_clear || (count_nxt == '0)),
        .restart_i  (push || (data_rd_i && (count_nxt != '0))),
        .tick_i     (bit_tick_i),
        .fmt_i      (line_fmt_i),
        .nonempty_i (count != '0),
        .pend_o     (timeout_pend_o)
    );

    // Line status flags
    assign empties = data_rd_i && (count_nxt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_q <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            if (rx_break_i && !rx_clear)   brk_q <= 1'b1;
            else if (lsr_rd_i || empties)  brk_q <= 1'b0;
            if (drop)                      ovr_q <= 1'b1;
            else if (lsr_rd_i)             ovr_q <= 1'b0;
        end
    end

    assign trig_lvl     = CNT_W'(trig_bytes(trig_code_q, DEPTH));
    assign fifo_en_o    = fcr_q[B_EN];
    assign fill_o       = count;
    assign data_ready_o = (count != '0);
    assign at_trig_o    = fcr_q[B_EN] ? (count >= trig_lvl) : (count != '0);
    assign break_o      = brk_q;
    assign overrun_o    = ovr_q;

    p_empty_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd_i && fill_o == '0) |-> (rd_data_o == '0));

    p_break_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_break_i && !rx_clear) |=> (break_o && data_ready_o));

    p_lsr_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd_i && !rx_break_i && !drop) |=> (!break_o && !overrun_o));

    p_read_clears_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd_i |=> !timeout_pend_o);

    p_same_write_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fctl_we_i && fctl_wdata_i == fcr_q && !rx_valid_i && !rx_break_i && !data_rd_i)
        |=> ($stable(fill_o) && $stable(fifo_en_o)));

    p_same_write_noflush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fctl_we_i && fctl_wdata_i == fcr_q) |-> !tx_flush_o);

    p_trig_needs_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
        at_trig_o |-> data_ready_o);

endmodule

// File: tb/uart_rxq_tb_top.sv
`timescale 1ns/1ps
module uart_rxq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid_i = 1'b0;
    logic [7:0] rx_byte_i = '0;
    logic       rx_break_i = 1'b0;
    logic       data_rd_i = 1'b0;
    logic       lsr_rd_i = 1'b0;
    logic       fctl_we_i = 1'b0;
    logic [7:0] fctl_wdata_i = '0;
    logic [3:0] line_fmt_i = '0;
    logic       bit_tick_i = 1'b0;
    logic [7:0] rd_data_o;
    logic       fifo_en_o;
    logic [4:0] fill_o;
    logic       at_trig_o, data_ready_o, break_o, overrun_o, timeout_pend_o, tx_flush_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] got;
    logic       flush_seen;

    always #10 clk = ~clk;

    uart_rxq dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i),
        .rx_break_i(rx_break_i), .data_rd_i(data_rd_i), .lsr_rd_i(lsr_rd_i),
        .fctl_we_i(fctl_we_i), .fctl_wdata_i(fctl_wdata_i), .line_fmt_i(line_fmt_i),
        .bit_tick_i(bit_tick_i), .rd_data_o(rd_data_o), .fifo_en_o(fifo_en_o),
        .fill_o(fill_o), .at_trig_o(at_trig_o), .data_ready_o(data_ready_o),
        .break_o(break_o), .overrun_o(overrun_o), .timeout_pend_o(timeout_pend_o),
        .tx_flush_o(tx_flush_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic rx(input logic [7:0] b);
        rx_valid_i = 1'b1; rx_byte_i = b;
        @(negedge clk);
        rx_valid_i = 1'b0;
    endtask

    task automatic brk();
        rx_break_i = 1'b1;
        @(negedge clk);
        rx_break_i = 1'b0;
    endtask

    task automatic rd(output logic [7:0] d);
        data_rd_i = 1'b1;
        #1 d = rd_data_o;
        @(negedge clk);
        data_rd_i = 1'b0;
    endtask

    task automatic lsr();
        lsr_rd_i = 1'b1;
        @(negedge clk);
        lsr_rd_i = 1'b0;
    endtask

    task automatic fcw(input logic [7:0] v);
        fctl_we_i = 1'b1; fctl_wdata_i = v;
        #1 flush_seen = tx_flush_o;
        @(negedge clk);
        fctl_we_i = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick_i = 1'b1;
            @(negedge clk);
        end
        bit_tick_i = 1'b0;
    endtask

    function automatic int char_len(input int f);
        return 1 + (f % 4) + 5 + ((f >> 3) & 1) + (((f >> 2) & 1) != 0 ? 2 : 1);
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10 fill", fill_o, 0);
        chk("R10 fifo_en", fifo_en_o, 0);
        chk("R10 flags", {break_o, overrun_o, timeout_pend_o, data_ready_o, at_trig_o}, 0);

        // R9 disabled mode: single holding register
        rx(8'h11);
        chk("R9 fill one", fill_o, 1);
        chk("R9 trig equals ready", at_trig_o, 1);
        rx(8'h22);
        chk("R9 still one", fill_o, 1);
        chk("R9 overrun", overrun_o, 1);
        tick(60);
        chk("R9 no timeout", timeout_pend_o, 0);
        rd(got);
        chk("R9 newest kept", got, 8'h22);
        chk("R9 ready cleared", data_ready_o, 0);
        lsr();
        chk("R5 overrun cleared", overrun_o, 0);

        // R8 enable: flips bit 0, forces flushes
        fcw(8'h01);
        chk("R8 enable flush", flush_seen, 1);
        chk("R8 enabled", fifo_en_o, 1);

        // R1 R2 R3 trigger sweep, order, overrun drop
        for (int c = 0; c < 4; c++) begin
            int lvl;
            lvl = (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14;
            fcw(8'((c << 6) | 3));
            chk("R8 rx flush no tx flush", flush_seen, 0);
            chk("R8 flushed", fill_o, 0);
            for (int k = 1; k <= 16; k++) begin
                rx(8'(c * 32 + k));
                chk("R1 fill", fill_o, k);
                chk("R1 trigger", at_trig_o, (k >= lvl) ? 1 : 0);
            end
            rx(8'hEE);
            chk("R2 fill held", fill_o, 16);
            chk("R2 overrun", overrun_o, 1);
            lsr();
            chk("R5 overrun clear", overrun_o, 0);
            for (int k = 1; k <= 16; k++) begin
                rd(got);
                chk("R3 order", got, c * 32 + k);
            end
            chk("R3 ready clear", data_ready_o, 0);
            rd(got);
            chk("R3 empty reads zero", got, 0);
        end

        // R8 same value ignored (stored 0xC1)
        rx(8'h01); rx(8'h02); rx(8'h03);
        fcw(8'hC1);
        chk("R8 same value fill", fill_o, 3);
        chk("R8 same value no flush", flush_seen, 0);
        fcw(8'hC7);
        chk("R8 flush both", flush_seen, 1);
        chk("R8 flushed rx", fill_o, 0);
        chk("R8 still enabled", fifo_en_o, 1);

        // R6 timeout sweep over all line formats
        fcw(8'h03);
        for (int f = 0; f < 16; f++) begin
            int lim;
            line_fmt_i = 4'(f);
            lim = 4 * char_len(f);
            rx(8'(f + 8'h40));
            tick(lim - 1);
            chk("R6 not yet", timeout_pend_o, 0);
            tick(1);
            chk("R6 fired", timeout_pend_o, 1);
            rd(got);
            chk("R6 data", got, f + 8'h40);
            chk("R7 read clears", timeout_pend_o, 0);
        end

        // R6 restart by partial read and by receive; R7 cancel
        line_fmt_i = 4'd0;
        rx(8'hA0); rx(8'hA1);
        tick(20);
        rd(got);
        tick(27);
        chk("R6 read restart", timeout_pend_o, 0);
        tick(1);
        chk("R6 read restart fire", timeout_pend_o, 1);
        rd(got);
        chk("R7 read clears empty", timeout_pend_o, 0);
        rx(8'hB0);
        tick(20);
        rx(8'hB1);
        tick(27);
        chk("R6 rx restart", timeout_pend_o, 0);
        tick(1);
        chk("R6 rx restart fire", timeout_pend_o, 1);
        rx(8'hB2);
        chk("R6 rx clears via restart", timeout_pend_o, 0);
        tick(28);
        rd(got);
        chk("R7 partial read clears", timeout_pend_o, 0);
        tick(28);
        chk("R7 fired again", timeout_pend_o, 1);
        fcw(8'h07);
        chk("R7 flush cancels", timeout_pend_o, 0);
        chk("R7 flush empties", fill_o, 0);
        tick(100);
        chk("R7 never when empty", timeout_pend_o, 0);

        // R4 break handling
        brk();
        chk("R4 fill", fill_o, 1);
        chk("R4 break", break_o, 1);
        chk("R4 ready", data_ready_o, 1);
        lsr();
        chk("R5 break cleared", break_o, 0);
        chk("R5 ready kept", data_ready_o, 1);
        rd(got);
        chk("R4 zero byte", got, 0);
        brk();
        rx(8'h55);
        rd(got);
        chk("R3 break kept nonempty", break_o, 1);
        rd(got);
        chk("R3 last byte", got, 8'h55);
        chk("R3 break cleared on empty", break_o, 0);

        // R5 set wins over clear; R4 break when full
        for (int k = 0; k < 16; k++) rx(8'(k + 8'h70));
        rx_valid_i = 1'b1; rx_byte_i = 8'hFF; lsr_rd_i = 1'b1;
        @(negedge clk);
        rx_valid_i = 1'b0; lsr_rd_i = 1'b0;
        chk("R5 overrun wins", overrun_o, 1);
        lsr();
        brk();
        chk("R4 break when full", break_o, 1);
        chk("R2 break overrun", overrun_o, 1);
        chk("R2 full kept", fill_o, 16);
        rd(got);
        chk("R2 head kept", got, 8'h70);

        summary();
        $finish;
    end

endmodule